// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Controller

This block sits between a processor bus and the bit-level serial engine of a serial port. It buffers outgoing bytes in a 16-entry transmit queue and incoming characters in a 16-entry receive queue. Each receive entry is 10 bits wide: 8 data bits plus a parity-error flag and a framing-error flag. Software reaches the block through simple read and write strobes on a small register space. Through that space it writes bytes to send, pops received characters, reads both fill levels, enables or flushes the queues, and services the interrupt status.

Fourteen status bits gather queue level conditions and event pulses from the serial engine: clear-to-send changes, break completion, character-time ticks for the receive timeout, overrun, underrun and bus misuse. A bit stays set until software writes a one to it. An enable mask selects which set bits raise the single level-sensitive, active-high interrupt line.

Register word addresses: 0 transmit data (write), 1 receive data (read, pops), 2 status (read, write-one-to-clear), 3 interrupt mask, 4 queue control, 5 fill index.

Top module: `sio_fifo_irq`

## Requirements
- R1: A write to address 0 while the queues are enabled appends wrData[7:0] to the transmit queue. When the queue already holds 16 bytes, the write is dropped. txData always shows the oldest byte, txValid is high while the queue is non-empty, and each txPop cycle removes one byte in first-in first-out order.
- R2: A read of address 1 returns the oldest receive entry in rdData[9:0] and removes it. Entries come out in arrival order, with all 10 bits intact.
- R3: Reading address 5 gives the transmit count in bits 4:0 and the receive count in bits 12:8. Every other bit reads 0, and each count stays within 0 to 16.
- R4: Queue control bit 0 is the enable. While it is 0, transmit writes and rxPush pulses are ignored: counts do not change and status bits 7, 8 and 9 are not set.
- R5: Writing a 1 to queue control bit 2 flushes the transmit queue, and writing a 1 to bit 3 flushes the receive queue. A flush bit reads 1 in the cycle after the write, then reads 0 with the queue empty.
- R6: Writing ones to address 2 clears the matching status bits, and writing zeros leaves them alone. A set condition present in the same cycle takes priority over the clear.
- R7: irq is high exactly while some status bit and its bit in the mask at address 3 are both 1.
- R8: An rxPush while the receive queue holds 16 entries drops the character, leaves the count at 16 and sets status bit 7.
- R9: Status bits 1 to 5 are set whenever their level holds: receive queue non-empty, transmit count at most 4, transmit empty, receive count at least 12, and receive full, in that order. Bit 0 sets when txPop takes the last transmit byte. Bit 6 sets on a txPop while the transmit queue is empty.
- R10: An accepted receive entry with bit 8 set sets status bit 8 (parity). One with bit 9 set sets status bit 9 (framing). A ctsToggle pulse sets bit 10, and a breakDone pulse sets bit 12.
- R11: Status bit 11 sets on the 4th charTick counted while the receive queue is non-empty. Any accepted rxPush, or an empty receive queue, restarts the count.
- R12: A read of address 1 while the receive queue is empty returns 0. It sets status bit 13 only when queue control bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt, active high |
| txPop | input | 1 | Serial engine takes the transmit head byte |
| txValid | output | 1 | Transmit queue non-empty |
| txData | output | 8 | Transmit head byte |
| rxPush | input | 1 | Serial engine delivers a character |
| rxIn | input | 10 | Received character: bit 9 framing error, bit 8 parity error, bits 7:0 data |
| ctsToggle | input | 1 | Pulse on a clear-to-send change |
| breakDone | input | 1 | Pulse when a break finishes |
| charTick | input | 1 | Pulse once per character time |

## Verification
Scoreboard queues hold the bytes and characters that are expected out. Short bursts separate ordering errors from count errors. A 17-deep burst into each queue shows that the full boundary drops exactly one item. The status tests alternate write-zero and write-one patterns on event bits to tell a sticky bit from a level-following one. The same pushes are repeated with the queues disabled to show they are ignored. Tick counts of 3 and then 4 bracket the timeout threshold. Empty reads with and without the error enable isolate the bus-error bit.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BUS_W  = 16;
  localparam int TX_W   = 8;
  localparam int RX_W   = 10;
  localparam int STAT_W = 14;

  localparam logic [2:0] ADR_TX   = 3'd0;
  localparam logic [2:0] ADR_RX   = 3'd1;
  localparam logic [2:0] ADR_STAT = 3'd2;
  localparam logic [2:0] ADR_MASK = 3'd3;
  localparam logic [2:0] ADR_FCTL = 3'd4;
  localparam logic [2:0] ADR_IDX  = 3'd5;

  typedef struct packed {
    logic            en;
    logic            txPush;
    logic [TX_W-1:0] txByte;
    logic            txClr;
    logic            rxPop;
    logic            rxClr;
  } fifoCmd_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != FULL);
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rstN)
    (push && count == FULL && !pop && !clr) |=> (count == FULL));
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoCmd_t                   cmd,
  input  logic                       txPop,
  input  logic                       rxPush,
  input  logic [RX_W-1:0]            rxIn,
  output logic [TX_W-1:0]            txHead,
  output logic [$clog2(DEPTH+1)-1:0] txCnt,
  output logic [RX_W-1:0]            rxHead,
  output logic [$clog2(DEPTH+1)-1:0] rxCnt
);
  sio_fifo #(.W(TX_W), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .clr(cmd.txClr),
    .push(cmd.txPush), .din(cmd.txByte),
    .pop(txPop), .dout(txHead), .count(txCnt)
  );

  sio_fifo #(.W(RX_W), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .clr(cmd.rxClr),
    .push(rxPush && cmd.en), .din(rxIn),
    .pop(cmd.rxPop), .dout(rxHead), .count(rxCnt)
  );
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4,
  parameter int AFULL_LVL  = 12,
  parameter int AEMPTY_LVL = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [2:0]                 addr,
  input  logic [BUS_W-1:0]           wrData,
  output logic [BUS_W-1:0]           rdData,
  output logic                       irq,
  input  logic                       txPop,
  input  logic                       rxPush,
  input  logic [1:0]                 rxErr,
  input  logic                       ctsToggle,
  input  logic                       breakDone,
  input  logic                       charTick,
  input  logic [$clog2(DEPTH+1)-1:0] txCnt,
  input  logic [$clog2(DEPTH+1)-1:0] rxCnt,
  input  logic [RX_W-1:0]            rxHead,
  output fifoCmd_t                   cmd
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TOUT_CHARS+1);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] AFULL  = CW'(AFULL_LVL);
  localparam logic [CW-1:0] AEMPTY = CW'(AEMPTY_LVL);
  localparam logic [TW-1:0] TLAST  = TW'(TOUT_CHARS-1);
  localparam logic [TW-1:0] TMAX   = TW'(TOUT_CHARS);

  logic              fifoEn, errOnEmpty, txRstPend, rxRstPend;
  logic [STAT_W-1:0] stat, mask, setVec, clrMask;
  logic [TW-1:0]     toutCnt;
  logic              wrTx, wrStat, wrMask, wrFctl, rdRx;
  logic              rxAcc, toutFire;
  logic              unusedBits;

  assign unusedBits = ^wrData[BUS_W-1:STAT_W];

  assign wrTx   = wrEn && addr == ADR_TX;
  assign wrStat = wrEn && addr == ADR_STAT;
  assign wrMask = wrEn && addr == ADR_MASK;
  assign wrFctl = wrEn && addr == ADR_FCTL;
  assign rdRx   = rdEn && addr == ADR_RX;

  assign rxAcc    = rxPush && fifoEn && rxCnt != FULL;
  assign toutFire = charTick && rxCnt != '0 && !rxAcc && toutCnt == TLAST;
  assign clrMask  = wrStat ? wrData[STAT_W-1:0] : '0;

  always_comb begin
    cmd        = '0;
    cmd.en     = fifoEn;
    cmd.txPush = wrTx && fifoEn;
    cmd.txByte = wrData[TX_W-1:0];
    cmd.txClr  = txRstPend;
    cmd.rxPop  = rdRx;
    cmd.rxClr  = rxRstPend;
  end

  always_comb begin
    setVec     = '0;
    setVec[0]  = txPop && txCnt == CW'(1);
    setVec[1]  = rxCnt != '0;
    setVec[2]  = txCnt <= AEMPTY;
    setVec[3]  = txCnt == '0;
    setVec[4]  = rxCnt >= AFULL;
    setVec[5]  = rxCnt == FULL;
    setVec[6]  = txPop && txCnt == '0;
    setVec[7]  = rxPush && fifoEn && rxCnt == FULL;
    setVec[8]  = rxAcc && rxErr[0];
    setVec[9]  = rxAcc && rxErr[1];
    setVec[10] = ctsToggle;
    setVec[11] = toutFire;
    setVec[12] = breakDone;
    setVec[13] = rdRx && rxCnt == '0 && errOnEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat       <= '0;
      mask       <= '0;
      fifoEn     <= 1'b0;
      errOnEmpty <= 1'b0;
      txRstPend  <= 1'b0;
      rxRstPend  <= 1'b0;
      toutCnt    <= '0;
    end else begin
      stat <= (stat & ~clrMask) | setVec;
      if (wrMask) mask <= wrData[STAT_W-1:0];
      if (wrFctl) begin
        fifoEn     <= wrData[0];
        errOnEmpty <= wrData[4];
      end
      txRstPend <= wrFctl && wrData[2];
      rxRstPend <= wrFctl && wrData[3];
      if (rxCnt == '0 || rxAcc)
        toutCnt <= '0;
      else if (charTick && toutCnt != TMAX)
        toutCnt <= toutCnt + 1'b1;
    end
  end

  assign irq = |(stat & mask);

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_RX:   rdData = (rxCnt != '0) ? BUS_W'(rxHead) : '0;
      ADR_STAT: rdData = BUS_W'(stat);
      ADR_MASK: rdData = BUS_W'(mask);
      ADR_FCTL: rdData = BUS_W'({errOnEmpty, rxRstPend, txRstPend, 1'b0, fifoEn});
      ADR_IDX:  rdData = (BUS_W'(rxCnt) << 8) | BUS_W'(txCnt);
      default:  rdData = '0;
    endcase
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(stat) & ~$past(clrMask)) & ~stat)) == '0));

  assert_rst_self_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txRstPend || rxRstPend) |=> (txCnt == '0 || !$past(txRstPend)) && (rxCnt == '0 || !$past(rxRstPend)));

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && fifoEn && rxCnt == FULL) |=> stat[7]);

  assert_empty_read_err_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxCnt == '0 && errOnEmpty) |=> stat[13]);
endmodule

// File: rtl/sio_fifo_irq.sv
module sio_fifo_irq
  import sio_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4,
  parameter int AFULL_LVL  = 12,
  parameter int AEMPTY_LVL = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irq,
  input  logic        txPop,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        rxPush,
  input  logic [9:0]  rxIn,
  input  logic        ctsToggle,
  input  logic        breakDone,
  input  logic        charTick
);
  localparam int CW = $clog2(DEPTH+1);

  fifoCmd_t        cmd;
  logic [CW-1:0]   txCnt, rxCnt;
  logic [RX_W-1:0] rxHead;

  assign txValid = txCnt != '0;

  sio_ctrl #(
    .DEPTH(DEPTH), .TOUT_CHARS(TOUT_CHARS),
    .AFULL_LVL(AFULL_LVL), .AEMPTY_LVL(AEMPTY_LVL)
  ) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txPop(txPop),
    .rxPush(rxPush), .rxErr(rxIn[9:8]), .ctsToggle(ctsToggle),
    .breakDone(breakDone), .charTick(charTick), .txCnt(txCnt),
    .rxCnt(rxCnt), .rxHead(rxHead), .cmd(cmd)
  );

  sio_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txPop(txPop),
    .rxPush(rxPush), .rxIn(rxIn), .txHead(txData), .txCnt(txCnt),
    .rxHead(rxHead), .rxCnt(rxCnt)
  );
endmodule

// File: tb/sim_sio_fifo_irq.sv
module sim_sio_fifo_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_TX = 3'd0, A_RX = 3'd1, A_ST = 3'd2,
                         A_MK = 3'd3, A_FC = 3'd4, A_IX = 3'd5;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, rdEn = 0, txPop = 0, rxPush = 0;
  logic ctsToggle = 0, breakDone = 0, charTick = 0;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic [9:0] rxIn = '0;
  logic irq, txValid;
  logic [7:0] txData;

  int nRun = 0, nFail = 0;
  logic benchEn = 0;
  logic [7:0] txQ[$];
  logic [9:0] rxQ[$];
  logic [15:0] d;

  sio_fifo_irq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txPop(txPop),
    .txValid(txValid), .txData(txData), .rxPush(rxPush), .rxIn(rxIn),
    .ctsToggle(ctsToggle), .breakDone(breakDone), .charTick(charTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every transmit byte taken by the engine with the scoreboard
  always @(negedge clk) begin
    if (rstN && txPop && txQ.size() > 0) begin
      logic [7:0] e;
      e = txQ.pop_front();
      chk("R1 tx order", int'(txData), int'(e));
      chk("R1 txValid", int'(txValid), 1);
    end
  end

  task automatic busWr(input logic [2:0] a, input logic [15:0] v);
    addr = a; wrData = v; wrEn = 1;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [15:0] v);
    addr = a; rdEn = 1;
    #2 v = rdData;
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic txWrite(input logic [7:0] b);
    if (benchEn && txQ.size() < 16) txQ.push_back(b);
    busWr(A_TX, {8'h0, b});
  endtask

  task automatic rxSend(input logic [9:0] v);
    if (benchEn && rxQ.size() < 16) rxQ.push_back(v);
    rxIn = v; rxPush = 1;
    @(posedge clk); #1 rxPush = 0;
  endtask

  task automatic rxDrain(input string req);
    while (rxQ.size() > 0) begin
      logic [9:0] e;
      e = rxQ.pop_front();
      busRd(A_RX, d);
      chk(req, int'(d), int'(e));
    end
  endtask

  task automatic coreTake(input int n);
    txPop = 1;
    repeat (n) @(posedge clk);
    #1 txPop = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) ctsToggle = 1;
    else if (which == 1) breakDone = 1;
    else charTick = 1;
    @(posedge clk); #1;
    ctsToggle = 0; breakDone = 0; charTick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    repeat (2) @(posedge clk); #1;

    // reset state
    busRd(A_IX, d); chk("R3 reset index", int'(d), 0);
    busRd(A_FC, d); chk("R5 reset control", int'(d), 0);
    busRd(A_ST, d); chk("R9 reset status levels", int'(d), 'h000C);
    chk("R7 irq low at reset", int'(irq), 0);

    // transmit path, short burst
    busWr(A_FC, 16'h0001); benchEn = 1;
    txWrite(8'h3C); txWrite(8'hA5); txWrite(8'h01);
    busRd(A_IX, d); chk("R3 tx count 3", int'(d), 'h0003);
    busWr(A_ST, 16'h3FFF);
    coreTake(3);
    #1 chk("R1 txValid low after drain", int'(txValid), 0);
    busRd(A_ST, d); chk("R9 bit0 last byte taken", int'(d[0]), 1);

    // transmit full boundary
    for (int i = 0; i < 17; i++) txWrite(8'(8'h40 + i));
    busRd(A_IX, d); chk("R1 tx full holds 16", int'(d), 'h0010);
    busWr(A_ST, 16'h3FFF);
    busRd(A_ST, d); chk("R9 bit2 off at 16", int'(d[2]), 0);
    chk("R9 bit3 off at 16", int'(d[3]), 0);
    coreTake(16);
    chk("R1 all bytes taken", txQ.size(), 0);

    // underrun
    busWr(A_ST, 16'h3FFF);
    coreTake(1);
    busRd(A_ST, d); chk("R9 bit6 underrun", int'(d[6]), 1);

    // receive path with error flags
    busWr(A_ST, 16'h3FFF);
    rxSend(10'h0A5); rxSend(10'h1C3); rxSend(10'h23C);
    busRd(A_IX, d); chk("R3 rx count 3", int'(d), 'h0300);
    busRd(A_ST, d);
    chk("R10 parity bit8", int'(d[8]), 1);
    chk("R10 framing bit9", int'(d[9]), 1);
    chk("R9 bit1 rx non-empty", int'(d[1]), 1);
    rxDrain("R2 rx order");

    // overrun
    busWr(A_ST, 16'h3FFF);
    for (int i = 0; i < 17; i++) rxSend(10'(i + 16));
    busRd(A_IX, d); chk("R8 rx count stays 16", int'(d), 'h1000);
    busRd(A_ST, d);
    chk("R8 overrun bit7", int'(d[7]), 1);
    chk("R9 bit4 almost full", int'(d[4]), 1);
    chk("R9 bit5 full", int'(d[5]), 1);
    rxDrain("R8 rx kept first 16");

    // receive flush
    rxSend(10'h011); rxSend(10'h022); rxQ.delete();
    busWr(A_FC, 16'h0009);
    busRd(A_FC, d); chk("R5 rx flush bit reads 1", int'(d), 'h0009);
    busRd(A_FC, d); chk("R5 rx flush bit returns 0", int'(d), 'h0001);
    busRd(A_IX, d); chk("R5 rx emptied", int'(d), 0);

    // transmit flush
    txWrite(8'h77); txWrite(8'h88); txQ.delete();
    busWr(A_FC, 16'h0005);
    busRd(A_FC, d); chk("R5 tx flush bit reads 1", int'(d), 'h0005);
    busRd(A_FC, d); chk("R5 tx flush bit returns 0", int'(d), 'h0001);
    busRd(A_IX, d); chk("R5 tx emptied", int'(d), 0);

    // disabled queues
    busWr(A_FC, 16'h0000); benchEn = 0;
    busWr(A_ST, 16'h3FFF);
    txWrite(8'h55);
    rxSend(10'h1FF);
    busRd(A_IX, d); chk("R4 disabled counts unchanged", int'(d), 0);
    busRd(A_ST, d); chk("R4 disabled no parity flag", int'(d[8]), 0);
    busWr(A_FC, 16'h0001); benchEn = 1;

    // write-one-to-clear
    busWr(A_ST, 16'h3FFF);
    pulse(0);
    busRd(A_ST, d); chk("R10 cts bit10", int'(d[10]), 1);
    busWr(A_ST, 16'h0000);
    busRd(A_ST, d); chk("R6 write zero keeps bit10", int'(d[10]), 1);
    busWr(A_ST, 16'h0400);
    busRd(A_ST, d); chk("R6 write one clears bit10", int'(d[10]), 0);
    pulse(1);
    busRd(A_ST, d); chk("R10 break bit12", int'(d[12]), 1);
    busWr(A_ST, 16'h1000);
    busRd(A_ST, d); chk("R6 clears bit12", int'(d[12]), 0);

    // interrupt line
    busWr(A_MK, 16'h0400);
    chk("R7 irq low with masked bit clear", int'(irq), 0);
    pulse(0);
    chk("R7 irq high", int'(irq), 1);
    busWr(A_ST, 16'h0400);
    chk("R7 irq low after clear", int'(irq), 0);
    busWr(A_MK, 16'h0000);

    // receive timeout
    rxSend(10'h05A);
    busWr(A_ST, 16'h3FFF);
    repeat (3) pulse(2);
    busRd(A_ST, d); chk("R11 no timeout after 3 ticks", int'(d[11]), 0);
    pulse(2);
    busRd(A_ST, d); chk("R11 timeout after 4 ticks", int'(d[11]), 1);
    rxDrain("R2 rx after timeout");

    // empty read
    busWr(A_ST, 16'h3FFF);
    busRd(A_RX, d); chk("R12 empty read data", int'(d), 0);
    busRd(A_ST, d); chk("R12 no error without enable", int'(d[13]), 0);
    busWr(A_FC, 16'h0011);
    busRd(A_RX, d); chk("R12 empty read data enabled", int'(d), 0);
    busRd(A_ST, d); chk("R12 error bit13 set", int'(d[13]), 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule